// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

The block keeps a free-running 63-bit event counter. The counter advances by one on each cycle that `tick_en` is high. A limit register sits beside it. When a tick brings the count up to the limit, the block sets a sticky soft-interrupt bit and sends a one-cycle wake pulse to the core. Each 64-bit register keeps its most significant bit as a separate flag. In the counter this flag marks the count as readable only with privilege. In the limit it turns compare interrupts off.

Software writes either register with a full 64-bit word and reads it back in the same split form. A zero limit never produces an interrupt. A limit written at or behind the current count is not lost: it fires on the next tick. A system uses one instance for each timer it needs (for example ordinary, system and hypervisor tick), and all instances share the same `tick_en`.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, `cnt_rdata` reads 0x8000_0000_0000_0000 (flag set, count zero), `lim_rdata` reads 0x8000_0000_0000_0000 (disable set, limit zero), and `sint` and `wake` are 0.
- R2: On each cycle with `tick_en` high and no counter write, the count in bits 62:0 goes up by one. From 0x7FFF_FFFF_FFFF_FFFF it wraps to zero without touching bit 63. With `tick_en` low the count holds.
- R3: A counter write loads `cnt_wdata[62:0]` into the count and `cnt_wdata[63]` into the privilege flag. It overrides a tick in the same cycle, and it shows on `cnt_rdata` the cycle after.
- R4: `cnt_rdata[63]` equals the stored privilege flag, whatever the count is.
- R5: A limit write stores `lim_wdata[62:0]` as the compare value and `lim_wdata[63]` as the interrupt-disable flag. `lim_rdata` returns both in the cycle after.
- R6: Suppose a tick, with no counter write in that cycle, moves the count to a value equal to a nonzero limit while disable is clear. Then `sint` is 1 and `wake` is high in the cycle after that tick. A counter write that loads the limit value does not fire.
- R7: A compare value of zero never fires, even when the count wraps to zero.
- R8: While the disable flag is set, no tick fires, even on an exact match.
- R9: Suppose a limit write with disable clear and a nonzero compare value less than or equal to the count at the time of the write. Then the next tick (with no counter write) fires as in R6. A later limit write before that tick replaces this pending event.
- R10: `sint` stays at 1 until a cycle with `sint_clr` high, and is 0 the cycle after that. If a fire and `sint_clr` happen in the same cycle, `sint` is 1.
- R11: `wake` is high for exactly one cycle for each fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-enable pulse, one increment per high cycle |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 64 | Counter write value: bit 63 is the privilege flag, bits 62:0 are the count |
| cnt_rdata | output | 64 | Counter read value: the privilege flag and the count |
| lim_wr | input | 1 | Limit write strobe |
| lim_wdata | input | 64 | Limit write value: bit 63 is disable, bits 62:0 are the compare value |
| lim_rdata | output | 64 | Limit read value: the disable flag and the compare value |
| sint_clr | input | 1 | Clears the soft-interrupt bit |
| sint | output | 1 | Sticky soft-interrupt timer bit |
| wake | output | 1 | One-cycle wake pulse to the core |

## Verification
Every result is due one clock edge after the stimulus that causes it. Register writes show on the read ports the cycle after the strobe. A tick that matches, or a pending late event, makes `sint` and `wake` visible in the cycle after that tick's edge. The driver applies stimulus on the falling edge. For each cycle it pushes the expected port values onto a queue, taken from an independent model of the requirements. The monitor pops one entry 2 ns after each rising edge, so each comparison lands exactly on the cycle the result is due.

// File: rtl/tick_pkg.sv
// Shared definitions for the tick/compare timer.
// Assumes: all instances in a system use the same count width.
package tick_pkg;
    localparam int unsigned TICK_CNT_W = 63;

    // Reason a compare event fired in a given cycle.
    typedef enum logic [1:0] {
        FIRE_NONE  = 2'd0,
        FIRE_MATCH = 2'd1,
        FIRE_LATE  = 2'd2
    } fire_src_e;
endpackage

// File: rtl/tick_count.sv
// Running counter plus its separately held privilege flag.
// Assumes: a write overrides a tick in the same cycle; the count wraps at all-ones.
module tick_count #(
    parameter int unsigned CNT_W = tick_pkg::TICK_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr,
    input  logic [CNT_W:0]   wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             npt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Next value on a tick, wrapping to zero after the maximum.
    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end

    // Count register and privilege flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            npt_q <= 1'b1;
        end else if (wr) begin
            cnt_q <= wdata[CNT_W-1:0];
            npt_q <= wdata[CNT_W];
        end else if (tick_en) begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/tick_compare.sv
// Limit register, disable flag and fire decision, including late limits.
// Assumes: a limit write takes effect the cycle after; a late limit is one at or
// behind the count at the time of the write, and it fires on the next valid tick.
module tick_compare #(
    parameter int unsigned CNT_W = tick_pkg::TICK_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic [CNT_W:0]   lim_wdata,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic             tick_ok,
    output logic [CNT_W-1:0] lim_q,
    output logic             dis_q,
    output logic             fire
);
    import tick_pkg::*;

    logic      late_q;
    logic      armed;
    fire_src_e src;
    logic      wr_late;

    // Enabled with a nonzero compare value.
    always_comb begin
        armed = !dis_q && (lim_q != '0);
    end

    // Choose the fire source for this cycle.
    always_comb begin
        src = FIRE_NONE;
        if (tick_ok && armed) begin
            if (late_q)                src = FIRE_LATE;
            else if (cnt_inc == lim_q) src = FIRE_MATCH;
        end
        fire = (src != FIRE_NONE);
    end

    // A new limit that is already reached becomes a pending late event.
    always_comb begin
        wr_late = !lim_wdata[CNT_W] && (lim_wdata[CNT_W-1:0] != '0)
                  && (lim_wdata[CNT_W-1:0] <= cnt_q);
    end

    // Limit, disable flag and pending-late state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= '0;
            dis_q  <= 1'b1;
            late_q <= 1'b0;
        end else if (lim_wr) begin
            lim_q  <= lim_wdata[CNT_W-1:0];
            dis_q  <= lim_wdata[CNT_W];
            late_q <= wr_late;
        end else if (src == FIRE_LATE) begin
            late_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tick_sint.sv
// Sticky soft-interrupt bit and one-cycle wake pulse.
// Assumes: when a set and a clear arrive together, the set wins.
module tick_sint (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic sint,
    output logic wake
);
    // Sticky bit with set priority, plus the registered wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sint <= 1'b0;
            wake <= 1'b0;
        end else begin
            wake <= fire;
            if (fire)     sint <= 1'b1;
            else if (clr) sint <= 1'b0;
        end
    end
endmodule

// File: rtl/tick_cmp_timer.sv
// Top level: counter with privilege flag, limit with disable, sticky interrupt.
// Assumes: tick_en is a clock-enable shared by all instances; the read ports are
// combinational views of the stored registers.
module tick_cmp_timer #(
    parameter int unsigned CNT_W = tick_pkg::TICK_CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           cnt_wr,
    input  logic [CNT_W:0] cnt_wdata,
    output logic [CNT_W:0] cnt_rdata,
    input  logic           lim_wr,
    input  logic [CNT_W:0] lim_wdata,
    output logic [CNT_W:0] lim_rdata,
    input  logic           sint_clr,
    output logic           sint,
    output logic           wake
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             npt_q;
    logic [CNT_W-1:0] lim_q;
    logic             dis_q;
    logic             fire;
    logic             tick_ok;

    // A tick counts for compare only when no counter write overrides it.
    always_comb begin
        tick_ok = tick_en && !cnt_wr;
    end

    tick_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr      (cnt_wr),
        .wdata   (cnt_wdata),
        .cnt_q   (cnt_q),
        .cnt_inc (cnt_inc),
        .npt_q   (npt_q)
    );

    tick_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lim_wr    (lim_wr),
        .lim_wdata (lim_wdata),
        .cnt_q     (cnt_q),
        .cnt_inc   (cnt_inc),
        .tick_ok   (tick_ok),
        .lim_q     (lim_q),
        .dis_q     (dis_q),
        .fire      (fire)
    );

    tick_sint u_sint (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .clr   (sint_clr),
        .sint  (sint),
        .wake  (wake)
    );

    // Read views: each flag rejoins its field in the top bit.
    always_comb begin
        cnt_rdata = {npt_q, cnt_q};
        lim_rdata = {dis_q, lim_q};
    end
endmodule

// File: rtl/tick_cmp_timer_chk.sv
// Port-level properties of tick_cmp_timer, attached through bind.
// Assumes: synchronous active-low reset; every property is one cycle deep.
module tick_cmp_timer_chk #(
    parameter int unsigned CNT_W = tick_pkg::TICK_CNT_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           cnt_wr,
    input logic [CNT_W:0] cnt_wdata,
    input logic [CNT_W:0] cnt_rdata,
    input logic           lim_wr,
    input logic [CNT_W:0] lim_wdata,
    input logic [CNT_W:0] lim_rdata,
    input logic           sint_clr,
    input logic           sint,
    input logic           wake
);
    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !tick_en) |=> $stable(cnt_rdata));

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_rdata == $past(cnt_wdata)));

    // R5
    limit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_wr |=> (lim_rdata == $past(lim_wdata)));

    // R6
    wake_sets_sint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> sint);

    // R7
    zero_limit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_rdata[CNT_W-1:0] == '0) |=> !wake);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_rdata[CNT_W] |=> !wake);

    // R10
    sint_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sint && !sint_clr) |=> sint);

    // R10
    sint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sint_clr && !$rose(wake)) |=> (!sint || wake));
endmodule

bind tick_cmp_timer tick_cmp_timer_chk #(.CNT_W(CNT_W)) u_tick_chk (.*);

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;
    localparam int unsigned W = 63;
    localparam logic [W-1:0] MAXC = {W{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [63:0] cnt_wdata = '0;
    logic [63:0] cnt_rdata;
    logic        lim_wr = 1'b0;
    logic [63:0] lim_wdata = '0;
    logic [63:0] lim_rdata;
    logic        sint_clr = 1'b0;
    logic        sint;
    logic        wake;

    always #4 clk = ~clk;

    tick_cmp_timer i_tick_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .lim_rdata(lim_rdata),
        .sint_clr(sint_clr), .sint(sint), .wake(wake)
    );

    // Scoreboard queues, one entry per cycle.
    string       q_tag[$];
    logic [63:0] q_cnt[$];
    logic [63:0] q_lim[$];
    logic        q_sint[$];
    logic        q_wake[$];

    int n_vec = 0;
    int n_err = 0;

    // Reference state held in the bench.
    logic [W-1:0] m_cnt = '0;
    logic         m_npt = 1'b1;
    logic [W-1:0] m_lim = '0;
    logic         m_dis = 1'b1;
    logic         m_late = 1'b0;
    logic         m_sint = 1'b0;

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input string tag, input logic tk, input logic cw,
                        input logic [63:0] cwd, input logic lw,
                        input logic [63:0] lwd, input logic clr);
        logic [W-1:0] nxt;
        logic         fire;
        logic         late_n;
        @(negedge clk);
        tick_en = tk; cnt_wr = cw; cnt_wdata = cwd;
        lim_wr = lw; lim_wdata = lwd; sint_clr = clr;
        nxt  = (m_cnt == MAXC) ? '0 : m_cnt + 1'b1;
        fire = tk && !cw && !m_dis && (m_lim != '0) && (m_late || nxt == m_lim);
        if (lw) late_n = !lwd[63] && (lwd[W-1:0] != '0) && (lwd[W-1:0] <= m_cnt);
        else    late_n = fire ? 1'b0 : m_late;
        m_late = late_n;
        if (cw) begin m_cnt = cwd[W-1:0]; m_npt = cwd[63]; end
        else if (tk) m_cnt = nxt;
        if (lw) begin m_lim = lwd[W-1:0]; m_dis = lwd[63]; end
        if (fire) m_sint = 1'b1;
        else if (clr) m_sint = 1'b0;
        q_tag.push_back(tag);
        q_cnt.push_back({m_npt, m_cnt});
        q_lim.push_back({m_dis, m_lim});
        q_sint.push_back(m_sint);
        q_wake.push_back(fire);
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask
    task automatic tick(input string tag);
        step(tag, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask
    task automatic wcnt(input string tag, input logic [63:0] v);
        step(tag, 1'b0, 1'b1, v, 1'b0, '0, 1'b0);
    endtask
    task automatic wlim(input string tag, input logic [63:0] v);
        step(tag, 1'b0, 1'b0, '0, 1'b1, v, 1'b0);
    endtask
    task automatic clr_sint(input string tag);
        step(tag, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
    endtask

    // Monitor: pops one expected entry per cycle, 2 ns after the rising edge.
    always @(posedge clk) begin
        #2;
        if (q_tag.size() > 0) begin
            string t;
            logic [63:0] ec, el;
            logic es, ew;
            t = q_tag.pop_front(); ec = q_cnt.pop_front(); el = q_lim.pop_front();
            es = q_sint.pop_front(); ew = q_wake.pop_front();
            n_vec++;
            if (cnt_rdata !== ec) begin
                n_err++;
                $display("FAIL %s cnt_rdata actual=%h expected=%h", t, cnt_rdata, ec);
            end
            if (lim_rdata !== el) begin
                n_err++;
                $display("FAIL %s lim_rdata actual=%h expected=%h", t, lim_rdata, el);
            end
            if (sint !== es) begin
                n_err++;
                $display("FAIL %s sint actual=%b expected=%b", t, sint, es);
            end
            if (wake !== ew) begin
                n_err++;
                $display("FAIL %s wake actual=%b expected=%b", t, wake, ew);
            end
        end
    end

    // Watchdog.
    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        idle("R1");
        // R2: increments and hold
        tick("R2"); tick("R2"); idle("R2"); tick("R2");
        // R3 R4: write with flag clear, then flag set overriding a tick
        wcnt("R3", 64'h0000_0000_0000_0010);
        idle("R4");
        step("R3", 1'b1, 1'b1, 64'h8000_0000_0000_0005, 1'b0, '0, 1'b0);
        tick("R4");
        // R2: wrap from maximum keeps the flag
        wcnt("R2", 64'h7FFF_FFFF_FFFF_FFFF);
        tick("R2");
        tick("R2");
        // R5 R6: limit 4 enabled, tick up to match
        wlim("R5", 64'h0000_0000_0000_0004);
        tick("R6"); tick("R6"); tick("R6");
        // R11: wake lasts one cycle, R10: sint sticky
        idle("R11"); idle("R10"); tick("R10");
        clr_sint("R10"); idle("R10");
        // R6: counter write of the limit value does not fire
        wcnt("R6", 64'h0000_0000_0000_0004); idle("R6");
        // R10: fire and clear in the same cycle, set wins
        wcnt("R10", 64'h0000_0000_0000_0003);
        step("R10", 1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
        clr_sint("R10"); idle("R10");
        // R8: disabled limit does not fire on a match
        wlim("R8", 64'h8000_0000_0000_0014);
        wcnt("R8", 64'h0000_0000_0000_0013);
        tick("R8"); idle("R8");
        // R7: zero limit, count wraps to zero
        wlim("R7", 64'h0000_0000_0000_0000);
        wcnt("R7", 64'h7FFF_FFFF_FFFF_FFFF);
        tick("R7"); tick("R7");
        // R9: limit behind the count fires on the next tick
        wcnt("R9", 64'h0000_0000_0000_0032);
        wlim("R9", 64'h0000_0000_0000_001E);
        idle("R9"); tick("R9"); tick("R9");
        clr_sint("R9");
        // R9: limit equal to the count is late too
        wlim("R9", 64'h0000_0000_0000_0034);
        tick("R9"); clr_sint("R9");
        // R9: a pending late event is replaced by a new limit
        wlim("R9", 64'h0000_0000_0000_0001);
        wlim("R9", 64'h0000_0000_0000_0100);
        tick("R9"); tick("R9");
        // R8: late limit with disable set does not fire
        wlim("R8", 64'h8000_0000_0000_0001);
        tick("R8"); idle("R8");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule